// File: doc/BRIEF.md
# Segment LCD Frame Timing Controller

This block derives the frame-rate tick of a segment LCD driver from a slow reference clock. The reference arrives as a one-cycle strobe, `ref_tick`, in the system clock domain. A power-of-two prescaler divides the strobes first. A small integer divider then counts the prescaler outputs, and one `frame_pulse` cycle is produced each time both stages wrap. The waveform generator that drives commons and segments uses this pulse to step from one frame to the next.

Software programs the block through a simple word-addressed write/read port. It sets the division ratio, starts and stops the timer, and can reset the block. It also manages two interrupt sources: one for the end of every frame, and one for the completion of a requested disable. A stop request never cuts a frame short. The timer finishes the frame in progress, then halts and reports that it is done.

Register addresses on `addr`: 0 control (write), 1 rate (read/write), 2 status (read), 3 interrupt-enable set (write), 4 interrupt-enable clear (write), 5 interrupt mask (read), 6 interrupt flags (read, clear on read). Reads are combinational: `rdata` shows the addressed register in the same cycle `rd_en` is high, and shows zero otherwise.

Top module: `lcd_frame_timer`

## Requirements
- R1: Rate bits [2:0] hold a prescaler code c from 0 to 7. One prescaler output is produced every 8·2^c `ref_tick` strobes.
- R2: Rate bits [6:4] hold N-1, with N from 1 to 8. `frame_pulse` is high for exactly one cycle every N prescaler outputs. Only cycles with `ref_tick` high advance the counters.
- R3: Writing control bit 0 (enable) while stopped starts the timer. Status bit 0 reads 1 from the next cycle. This also holds when control bit 1 is set in the same write.
- R4: Writing control bit 1 (disable) while running leaves status bit 0 at 1 until the end of the current frame. That frame's pulse is still produced. In the same cycle as that pulse, status bit 0 reads 0 and interrupt flag bit 2 (disable done) is set. No further pulses follow.
- R5: Writing control bit 3 (soft reset) returns the status, rate, mask, flag and counter state to their reset values in one cycle. It overrides an enable bit in the same write.
- R6: While stopped, no `frame_pulse` occurs and the counters stay at zero. The first pulse after enable therefore comes 8·2^c·N strobes after the enabling write.
- R7: In a write to the set register (3) or the clear register (4), each 1 in bit 0 (frame) or bit 2 (disable done) sets or clears that mask bit. A 0 leaves the bit unchanged. Mask bit 1 always reads 0.
- R8: Flag bit 0 is latched at every frame end and flag bit 2 at disable completion. `irq` is high while any flag has its mask bit set, and stays low while a set flag is masked off.
- R9: Reading the flag register (6) clears all flags at the end of that cycle. An event in that same cycle survives the clear.
- R10: After reset, all registers read 0, and `frame_pulse` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe from the slow reference clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while rd_en is high |
| frame_pulse | output | 1 | One-cycle pulse at every frame end |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag read that falls in the same cycle as a new frame-end event. It is the only moment where the clear-on-read and a set compete. The stimulus uses the shortest frame (8 strobes with `ref_tick` held high) and counts negative edges from an observed pulse. This places the read strobe exactly in the cycle before the next pulse edge, then rereads to confirm the flag survived. A second subtle case is disable completion. The bench reads status just after the request to confirm the timer is still running, and reads it again at the pulse edge.

// File: rtl/lcd_ft_pkg.sv
package lcd_ft_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL  = 3'd0,
    A_RATE  = 3'd1,
    A_STAT  = 3'd2,
    A_ISET  = 3'd3,
    A_ICLR  = 3'd4,
    A_IMASK = 3'd5,
    A_IFLAG = 3'd6
  } lcd_ft_reg_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_DIS_BIT  = 1;
  localparam int CTL_SRST_BIT = 3;

  localparam int EVT_W     = 3;
  localparam int EVT_FRAME = 0;
  localparam int EVT_DIS   = 2;
  localparam logic [EVT_W-1:0] EVT_VALID = 3'b101;

  localparam int RATE_DIV_LSB = 4;

endpackage

// File: rtl/lcd_ft_divider.sv
module lcd_ft_divider #(
  parameter int PRESC_W   = 3,
  parameter int DIV_W     = 3,
  parameter int BASE_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               ref_tick,
  input  logic [PRESC_W-1:0] presc_code,
  input  logic [DIV_W-1:0]   div_m1,
  output logic               frame_end,
  output logic               cnt_idle
);

  localparam int PCNT_W = BASE_LOG2 + (1 << PRESC_W) - 1;

  logic [PCNT_W-1:0] pcnt_q, pcnt_d, plim;
  logic [DIV_W-1:0]  dcnt_q, dcnt_d;
  logic              step, p_last, d_last, presc_out;

  // terminal count of the prescaler: 2^(BASE_LOG2+code) - 1
  always_comb begin
    plim = (PCNT_W'(1) << (BASE_LOG2 + int'(presc_code))) - PCNT_W'(1);
  end

  // compare with >= so a ratio lowered mid-frame cannot strand a counter
  assign step      = run & ref_tick;
  assign p_last    = (pcnt_q >= plim);
  assign d_last    = (dcnt_q >= div_m1);
  assign presc_out = step & p_last;
  assign frame_end = presc_out & d_last;
  assign cnt_idle  = (pcnt_q == '0) && (dcnt_q == '0);

  always_comb begin
    pcnt_d = pcnt_q;
    dcnt_d = dcnt_q;
    if (!run) begin
      pcnt_d = '0;
      dcnt_d = '0;
    end else if (step) begin
      pcnt_d = p_last ? '0 : pcnt_q + PCNT_W'(1);
      if (presc_out) begin
        dcnt_d = d_last ? '0 : dcnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      dcnt_q <= dcnt_d;
    end
  end

endmodule

// File: rtl/lcd_ft_ctrl.sv
module lcd_ft_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_en,
  input  logic cmd_dis,
  input  logic cmd_srst,
  input  logic frame_end,
  output logic en,
  output logic dis_done
);

  logic en_q, en_d, pend_q, pend_d;

  assign en       = en_q;
  assign dis_done = frame_end & pend_q & ~cmd_srst;

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    if (cmd_srst) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
    end else if (frame_end && pend_q) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
    end else if (!en_q) begin
      if (cmd_en) begin
        en_d = 1'b1;
      end
      pend_d = 1'b0;
    end else if (cmd_dis) begin
      pend_d = 1'b1;
    end else if (cmd_en) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/lcd_ft_irq.sv
module lcd_ft_irq import lcd_ft_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             set_wr,
  input  logic             clr_wr,
  input  logic [EVT_W-1:0] wbits,
  input  logic             flag_rd,
  input  logic [EVT_W-1:0] events,
  output logic [EVT_W-1:0] mask,
  output logic [EVT_W-1:0] flags,
  output logic             irq
);

  logic [EVT_W-1:0] mask_q, mask_d, flags_q, flags_d;
  logic [EVT_W-1:0] set_bits, clr_bits, kept;

  assign set_bits = set_wr ? wbits : '0;
  assign clr_bits = clr_wr ? wbits : '0;
  assign kept     = flag_rd ? '0 : flags_q;

  always_comb begin
    if (srst) begin
      mask_d  = '0;
      flags_d = '0;
    end else begin
      mask_d  = ((mask_q | set_bits) & ~clr_bits) & EVT_VALID;
      flags_d = (kept | events) & EVT_VALID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      mask_q  <= mask_d;
      flags_q <= flags_d;
    end
  end

  assign mask  = mask_q;
  assign flags = flags_q;
  assign irq   = |(flags_q & mask_q);

endmodule

// File: rtl/lcd_ft_regs.sv
module lcd_ft_regs import lcd_ft_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 3,
  parameter int DIV_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [REG_AW-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               en,
  input  logic [EVT_W-1:0]   mask,
  input  logic [EVT_W-1:0]   flags,
  output logic [PRESC_W-1:0] presc_code,
  output logic [DIV_W-1:0]   div_m1,
  output logic               cmd_en,
  output logic               cmd_dis,
  output logic               cmd_srst,
  output logic               set_wr,
  output logic               clr_wr,
  output logic               flag_rd,
  output logic [EVT_W-1:0]   wbits,
  output logic [DATA_W-1:0]  rdata
);

  logic [PRESC_W-1:0] presc_q, presc_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               wr_ctrl, wr_rate;

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_rate  = wr_en && (addr == A_RATE);
  assign cmd_en   = wr_ctrl & wdata[CTL_EN_BIT];
  assign cmd_dis  = wr_ctrl & wdata[CTL_DIS_BIT];
  assign cmd_srst = wr_ctrl & wdata[CTL_SRST_BIT];
  assign set_wr   = wr_en && (addr == A_ISET);
  assign clr_wr   = wr_en && (addr == A_ICLR);
  assign flag_rd  = rd_en && (addr == A_IFLAG);
  assign wbits    = wdata[EVT_W-1:0];

  always_comb begin
    presc_d = presc_q;
    div_d   = div_q;
    if (cmd_srst) begin
      presc_d = '0;
      div_d   = '0;
    end else if (wr_rate) begin
      presc_d = wdata[PRESC_W-1:0];
      div_d   = wdata[RATE_DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      div_q   <= '0;
    end else begin
      presc_q <= presc_d;
      div_q   <= div_d;
    end
  end

  assign presc_code = presc_q;
  assign div_m1     = div_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_RATE: begin
          rdata[PRESC_W-1:0]           = presc_q;
          rdata[RATE_DIV_LSB +: DIV_W] = div_q;
        end
        A_STAT:  rdata[0]         = en;
        A_IMASK: rdata[EVT_W-1:0] = mask;
        A_IFLAG: rdata[EVT_W-1:0] = flags;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer import lcd_ft_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int PRESC_W   = 3,
  parameter int DIV_W     = 3,
  parameter int BASE_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              frame_pulse,
  output logic              irq
);

  logic [PRESC_W-1:0] presc_code;
  logic [DIV_W-1:0]   div_m1;
  logic               cmd_en, cmd_dis, cmd_srst;
  logic               set_wr, clr_wr, flag_rd;
  logic [EVT_W-1:0]   wbits, irq_mask, irq_flags, events;
  logic               en_q, dis_done, frame_end, cnt_idle, run;
  logic               pulse_q, pulse_d;

  lcd_ft_regs #(.DATA_W(DATA_W), .PRESC_W(PRESC_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .en(en_q), .mask(irq_mask), .flags(irq_flags),
    .presc_code(presc_code), .div_m1(div_m1), .cmd_en(cmd_en),
    .cmd_dis(cmd_dis), .cmd_srst(cmd_srst), .set_wr(set_wr),
    .clr_wr(clr_wr), .flag_rd(flag_rd), .wbits(wbits), .rdata(rdata)
  );

  lcd_ft_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .cmd_srst(cmd_srst), .frame_end(frame_end), .en(en_q),
    .dis_done(dis_done)
  );

  assign run = en_q & ~cmd_srst;

  lcd_ft_divider #(.PRESC_W(PRESC_W), .DIV_W(DIV_W), .BASE_LOG2(BASE_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .ref_tick(ref_tick),
    .presc_code(presc_code), .div_m1(div_m1), .frame_end(frame_end),
    .cnt_idle(cnt_idle)
  );

  always_comb begin
    events            = '0;
    events[EVT_FRAME] = frame_end;
    events[EVT_DIS]   = dis_done;
  end

  lcd_ft_irq u_irq (
    .clk(clk), .rst_n(rst_n), .srst(cmd_srst), .set_wr(set_wr),
    .clr_wr(clr_wr), .wbits(wbits), .flag_rd(flag_rd), .events(events),
    .mask(irq_mask), .flags(irq_flags), .irq(irq)
  );

  assign pulse_d = frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign frame_pulse = pulse_q;

endmodule

// File: rtl/lcd_ft_checker.sv
module lcd_ft_checker import lcd_ft_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_pulse,
  input logic             irq,
  input logic             en,
  input logic             srst,
  input logic             cnt_idle,
  input logic [EVT_W-1:0] mask,
  input logic [EVT_W-1:0] flags
);

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse);

  assert_pulse_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> $past(en));

  assert_idle_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> cnt_idle);

  assert_stop_at_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en) && !$past(srst)) |-> (frame_pulse && flags[EVT_DIS]));

  assert_srst_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) |-> (!en && mask == '0 && flags == '0));

  assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0 && flags != '0));

endmodule

bind lcd_frame_timer lcd_ft_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .irq(irq),
  .en(en_q), .srst(cmd_srst), .cnt_idle(cnt_idle), .mask(irq_mask),
  .flags(irq_flags)
);

// File: tb/lcd_frame_timer_bench.sv
module lcd_frame_timer_bench;

  typedef struct packed {
    logic [2:0]  p;
    logic [2:0]  d;
    logic [15:0] per;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 16'd8},
    '{3'd0, 3'd7, 16'd64},
    '{3'd1, 3'd2, 16'd48},
    '{3'd2, 3'd3, 16'd128},
    '{3'd3, 3'd0, 16'd64},
    '{3'd7, 3'd0, 16'd1024},
    '{3'd4, 3'd1, 16'd256}
  };

  logic        clk, rst_n, ref_tick, wr_en, rd_en, frame_pulse, irq;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        tick_half;
  int          n_chk, n_fail;
  logic        done;

  lcd_frame_timer u_lcd_frame_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .frame_pulse(frame_pulse), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) ref_tick <= tick_half ? ~ref_tick : 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_pulse(output int cyc);
    cyc = 0;
    while (!frame_pulse && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (frame_pulse) n++;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int c, n;
    done = 1'b0; n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    tick_half = 1'b0; ref_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 frame_pulse", {31'd0, frame_pulse}, 32'd0);
    check("R10 irq", {31'd0, irq}, 32'd0);
    rd(3'd2, v); check("R10 status", v, 32'd0);
    rd(3'd1, v); check("R10 rate", v, 32'd0);
    rd(3'd5, v); check("R10 mask", v, 32'd0);
    rd(3'd6, v); check("R10 flags", v, 32'd0);

    // R6 no pulses while stopped
    count_pulses(100, n); check("R6 stopped pulses", n, 0);

    // R1 R2 R6 vector table: latency from enable and steady period
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 32'h8);
      wr(3'd1, {25'd0, VECS[i].d, 1'b0, VECS[i].p});
      wr(3'd0, 32'h1);
      wait_pulse(c);
      check("R6 first frame latency", c, {16'd0, VECS[i].per});
      @(negedge clk);
      c = 1;
      while (!frame_pulse && c < 5000) begin @(negedge clk); c++; end
      check("R1 R2 frame period", c, {16'd0, VECS[i].per});
    end

    // R2 only ref_tick strobes advance: half-rate strobes double the period
    wr(3'd0, 32'h8);
    tick_half = 1'b1;
    wr(3'd1, 32'h10);
    wr(3'd0, 32'h1);
    wait_pulse(c);
    @(negedge clk);
    c = 1;
    while (!frame_pulse && c < 5000) begin @(negedge clk); c++; end
    check("R2 half-rate period", c, 32);
    tick_half = 1'b0;

    // R7 mask set and clear
    wr(3'd0, 32'h8);
    wr(3'd3, 32'h7);  rd(3'd5, v); check("R7 set", v, 32'h5);
    wr(3'd3, 32'h0);  rd(3'd5, v); check("R7 set zero no effect", v, 32'h5);
    wr(3'd4, 32'h1);  rd(3'd5, v); check("R7 clear bit0", v, 32'h4);
    wr(3'd4, 32'h0);  rd(3'd5, v); check("R7 clear zero no effect", v, 32'h4);
    wr(3'd4, 32'h4);  rd(3'd5, v); check("R7 clear bit2", v, 32'h0);

    // R8 R9 frame interrupt
    wr(3'd1, 32'h3);
    wr(3'd3, 32'h1);
    wr(3'd0, 32'h1);
    wait_pulse(c);
    check("R8 irq at frame", {31'd0, irq}, 32'd1);
    rd(3'd6, v); check("R8 frame flag", v, 32'h1);
    check("R9 irq after read", {31'd0, irq}, 32'd0);
    rd(3'd6, v); check("R9 flags cleared", v, 32'h0);
    wr(3'd4, 32'h1);
    @(negedge clk);
    wait_pulse(c);
    check("R8 masked flag no irq", {31'd0, irq}, 32'd0);
    rd(3'd6, v); check("R8 masked flag latched", v, 32'h1);

    // R4 disable completes at the frame boundary
    wr(3'd0, 32'h2);
    rd(3'd2, v); check("R4 still running", v, 32'h1);
    wait_pulse(c);
    check("R4 final pulse", {31'd0, frame_pulse}, 32'd1);
    rd(3'd2, v); check("R4 stopped after frame", v, 32'h0);
    rd(3'd6, v); check("R4 disable flag", v, 32'h5);
    count_pulses(200, n); check("R4 no pulses after stop", n, 0);

    // R3 enable plus disable in one write while stopped
    wr(3'd0, 32'h3);
    rd(3'd2, v); check("R3 enabled", v, 32'h1);

    // R5 soft reset overrides enable
    wr(3'd1, 32'h22);
    wr(3'd3, 32'h5);
    wr(3'd0, 32'h9);
    rd(3'd2, v); check("R5 status", v, 32'h0);
    rd(3'd1, v); check("R5 rate", v, 32'h0);
    rd(3'd5, v); check("R5 mask", v, 32'h0);
    count_pulses(100, n); check("R5 no pulses", n, 0);

    // R9 flag read coinciding with a new frame event
    wr(3'd0, 32'h1);
    wait_pulse(c);
    repeat (6) @(negedge clk);
    rd(3'd6, v);
    rd(3'd6, v); check("R9 same-cycle event kept", v & 32'h1, 32'h1);

    finish_run();
  end

endmodule